// File: doc/BRIEF.md
# Per-Pin Output Mode Controller for an 8-Bit I/O Port

This block holds the control registers of an 8-bit general-purpose I/O port and turns them into pad-driver enables for every pin. Software writes an output latch and two mode-selection registers; each pin's pair of mode bits picks one of four output types: quasi-bidirectional, push-pull, open-drain or input-only. The block decodes this pair, together with the pin's latch bit, into a strong pull-down, a strong pull-up and a weak pull-up enable.

On the input side, each pad value passes through a two-flop synchronizer and then a glitch filter. The filtered value is returned on the read port. A fourth register marks pins as analog. For an analog pin the digital input enable goes low, the read value is forced to 0 and the filter keeps its state.

One pin is fixed as input-only. A short strong pull-up kick is added when a quasi-bidirectional pin's latch goes from 0 to 1.

Top module: `gpio_mode_ctrl`

## Requirements
- R1: After reset every pin drives nothing (all three driver enables low) and every digital input enable is high. The registers read back as follows: latch 8'hFF, mode register A 8'hFF, mode register B 8'h00, analog select 8'h00.
- R2: Register select `addr_i` chooses the register. 0 writes the output latch and reads the filtered pin values. 1 selects mode register A, 2 selects mode register B and 3 selects analog select. A write with `wr_en_i` high takes effect at the next rising clock edge. For addresses 1 to 3 the read returns the stored register.
- R3: In quasi-bidirectional mode, latch 0 enables only the strong pull-down. Latch 1 enables the weak pull-up and, once any kick has ended, no other driver. The strong pull-down and strong pull-up are never enabled together on any pin.
- R4: In push-pull mode, latch 1 enables only the strong pull-up and latch 0 enables only the strong pull-down.
- R5: In open-drain mode, neither pull-up is ever enabled, and the pull-down is enabled exactly when the latch is 0.
- R6: In input-only mode, all three driver enables of the pin are low whatever the latch holds.
- R7: A pin's mode is {A bit, B bit}: 00 selects quasi-bidirectional, 01 push-pull, 10 input-only and 11 open-drain.
- R8: Pin 5 (parameter FIXED_IN_PIN) always behaves as input-only. Writes to its mode bits leave its three driver enables low.
- R9: When a quasi-bidirectional pin's latch goes from 0 to 1, its strong pull-up is high for exactly 2 clocks: the cycle after the write edge and the one after that. It then drops, leaving the weak pull-up on.
- R10: While a pin's analog bit is 1, its digital input enable is low, its read bit is 0 and its filter output holds. When the analog bit is cleared, the value held before the analog bit was set is read back at once.
- R11: A pad change shows on the read port at the fifth rising edge after it is applied, and not earlier: 2 synchronizer stages plus 3 stable clocks.
- R12: A pad pulse that lasts 2 clocks never reaches the read port. A pulse that lasts 3 clocks does reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for both write and read |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data (pin values or register) |
| pad_in_i | input | 8 | Raw pad input values |
| pd_en_o | output | 8 | Strong pull-down enable per pin |
| spu_en_o | output | 8 | Strong pull-up enable per pin |
| wpu_en_o | output | 8 | Weak pull-up enable per pin |
| din_en_o | output | 8 | Digital input enable per pin |

## Verification
The bench builds the block with its defaults: 8 pins, pin 5 fixed, a 2-clock kick, 2 synchronizer stages and a 3-clock filter. With these values the filter's edge cases are in reach: a 2-clock pulse that must be rejected, a 3-clock pulse that must pass, and the exact fifth-edge latency. The defaults also cover the two-cycle kick window and every mode mix across the pins, which the bench reaches with random register writes. The fixed pin stays among the randomly configured pins, so its drivers are checked under every mode value written to it.

// File: rtl/gpio_mode_pkg.sv
package gpio_mode_pkg;
  typedef enum logic [1:0] {
    MODE_QB = 2'b00,
    MODE_PP = 2'b01,
    MODE_IN = 2'b10,
    MODE_OD = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SEL_OUT  = 2'd0,
    SEL_CFGA = 2'd1,
    SEL_CFGB = 2'd2,
    SEL_ANA  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic pd;
    logic spu;
    logic wpu;
  } drv_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mode_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] out_q_o,
  output logic [W-1:0] cfga_q_o,
  output logic [W-1:0] cfgb_q_o,
  output logic [W-1:0] ana_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o  <= '1;
      cfga_q_o <= '1;   // {1,0} = input-only on every pin
      cfgb_q_o <= '0;
      ana_q_o  <= '0;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(addr_i))
        SEL_OUT:  out_q_o  <= wr_data_i;
        SEL_CFGA: cfga_q_o <= wr_data_i;
        SEL_CFGB: cfgb_q_o <= wr_data_i;
        SEL_ANA:  ana_q_o  <= wr_data_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_mode_pkg::*;
#(
  parameter int KICK = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       latch_i,
  input  logic       force_in_i,
  output drv_t       drv_o
);
  localparam int CW = (KICK > 1) ? $clog2(KICK) : 1;

  pin_mode_e     mode_eff;
  logic          latch_d;
  logic          rise;
  logic          kick;
  logic [CW-1:0] cnt_q;

  always_comb begin
    mode_eff  = force_in_i ? MODE_IN : pin_mode_e'(mode_i);
    rise      = latch_i & ~latch_d;
    kick      = (mode_eff == MODE_QB) && latch_i && (rise || cnt_q != '0);
    drv_o.pd  = !latch_i && (mode_eff != MODE_IN);
    drv_o.spu = latch_i && ((mode_eff == MODE_PP) || kick);
    drv_o.wpu = latch_i && (mode_eff == MODE_QB);
  end

  // rise cycle itself counts as the first kick clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_d <= 1'b1;
      cnt_q   <= '0;
    end else begin
      latch_d <= latch_i;
      if (mode_eff != MODE_QB)  cnt_q <= '0;
      else if (rise)            cnt_q <= CW'(KICK - 1);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/gpio_in_filt.sv
module gpio_in_filt #(
  parameter int SYNC = 2,
  parameter int FLEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pad_i,
  input  logic hold_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = (FLEN > 1) ? $clog2(FLEN) : 1;

  logic [SYNC-1:0] sync_q;
  logic [CW-1:0]   cnt_q;

  assign sync_o = sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC-2:0], pad_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!hold_i) begin
      if (sync_o == filt_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FLEN - 1)) begin
        filt_o <= sync_o;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_mode_ctrl.sv
module gpio_mode_ctrl
  import gpio_mode_pkg::*;
#(
  parameter int W            = 8,
  parameter int FIXED_IN_PIN = 5,
  parameter int KICK         = 2,
  parameter int SYNC         = 2,
  parameter int FLEN         = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pd_en_o,
  output logic [W-1:0] spu_en_o,
  output logic [W-1:0] wpu_en_o,
  output logic [W-1:0] din_en_o
);
  logic [W-1:0] out_q, cfga_q, cfgb_q, ana_q;
  logic [W-1:0] sync_v, filt_v;

  gpio_regs #(.W(W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .out_q_o  (out_q),
    .cfga_q_o (cfga_q),
    .cfgb_q_o (cfgb_q),
    .ana_q_o  (ana_q)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    drv_t drv;

    gpio_pin_drv #(.KICK(KICK)) u_drv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    ({cfga_q[i], cfgb_q[i]}),
      .latch_i   (out_q[i]),
      .force_in_i(i == FIXED_IN_PIN),
      .drv_o     (drv)
    );

    gpio_in_filt #(.SYNC(SYNC), .FLEN(FLEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pad_i (pad_in_i[i]),
      .hold_i(ana_q[i]),
      .sync_o(sync_v[i]),
      .filt_o(filt_v[i])
    );

    assign pd_en_o[i]  = drv.pd;
    assign spu_en_o[i] = drv.spu;
    assign wpu_en_o[i] = drv.wpu;
  end

  assign din_en_o = ~ana_q;

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_OUT:  rd_data_o = filt_v & ~ana_q;
      SEL_CFGA: rd_data_o = cfga_q;
      SEL_CFGB: rd_data_o = cfgb_q;
      SEL_ANA:  rd_data_o = ana_q;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mode_ctrl_chk.sv
module gpio_mode_ctrl_chk #(
  parameter int W     = 8,
  parameter int FIXED = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] pd,
  input logic [W-1:0] spu,
  input logic [W-1:0] wpu,
  input logic [W-1:0] din,
  input logic [W-1:0] cfga,
  input logic [W-1:0] cfgb,
  input logic [W-1:0] ana,
  input logic [W-1:0] sync,
  input logic [W-1:0] filt
);
  for (genvar i = 0; i < W; i++) begin : g_a
    assert_pd_spu_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pd[i] && spu[i]));

    assert_od_no_pullup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({cfga[i], cfgb[i]} == 2'b11) |-> (!spu[i] && !wpu[i]));

    assert_in_only_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({cfga[i], cfgb[i]} == 2'b10) |-> !(pd[i] || spu[i] || wpu[i]));

    assert_analog_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ana[i] |-> !din[i]);

    assert_analog_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ana[i] && $past(ana[i])) |-> $stable(filt[i]));

    assert_filt_from_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(filt[i]) |-> (filt[i] == $past(sync[i])));
  end

  assert_fixed_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd[FIXED] || spu[FIXED] || wpu[FIXED]));
endmodule

bind gpio_mode_ctrl gpio_mode_ctrl_chk #(.W(W), .FIXED(FIXED_IN_PIN)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .pd    (pd_en_o),
  .spu   (spu_en_o),
  .wpu   (wpu_en_o),
  .din   (din_en_o),
  .cfga  (cfga_q),
  .cfgb  (cfgb_q),
  .ana   (ana_q),
  .sync  (sync_v),
  .filt  (filt_v)
);

// File: tb/gpio_mode_ctrl_test.sv
module gpio_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int FIXED = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   addr_i = 2'd0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic [W-1:0] pad_in_i = '0;
  logic [W-1:0] pd_en_o, spu_en_o, wpu_en_o, din_en_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mode_ctrl uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .pad_in_i (pad_in_i),
    .pd_en_o  (pd_en_o),
    .spu_en_o (spu_en_o),
    .wpu_en_o (wpu_en_o),
    .din_en_o (din_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; addr_i = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr_i = a;
    #1 d = rd_data_o;
    addr_i = 2'd0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected {pd,spu,wpu} for a settled pin (no kick)
  function automatic logic [2:0] exp_drv(input logic a, input logic b, input logic l, input int pin);
    logic [1:0] m;
    m = (pin == FIXED) ? 2'b10 : {a, b};
    case (m)
      2'b00:   return l ? 3'b001 : 3'b100;
      2'b01:   return l ? 3'b010 : 3'b100;
      2'b11:   return l ? 3'b000 : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string mode_tag(input logic a, input logic b, input int pin);
    if (pin == FIXED) return "R8";
    case ({a, b})
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b11:   return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] ra, rb, rl;
    void'($urandom(32'h5eed_1234));

    cyc(3);
    rst_ni = 1'b1;
    cyc(2);

    // R1 reset state
    chk("R1 pd", pd_en_o, 8'h00);
    chk("R1 spu", spu_en_o, 8'h00);
    chk("R1 wpu", wpu_en_o, 8'h00);
    chk("R1 din", din_en_o, 8'hFF);
    rd(2'd1, d); chk("R1 cfga", d, 8'hFF);
    rd(2'd2, d); chk("R1 cfgb", d, 8'h00);
    rd(2'd3, d); chk("R1 ana", d, 8'h00);
    rd(2'd0, d); chk("R1 pins", d, 8'h00);

    // R2 register write/readback
    wr(2'd1, 8'h0F); wr(2'd2, 8'h33);
    rd(2'd1, d); chk("R2 cfga", d, 8'h0F);
    rd(2'd2, d); chk("R2 cfgb", d, 8'h33);

    // R7 encoding: pins 0,1 OD; 2,3 IN; 4 PP; 5 fixed; 6,7 QB
    wr(2'd0, 8'h00);
    chk("R7 pd latch0", pd_en_o, 8'hD3);
    chk("R7 spu latch0", spu_en_o, 8'h00);
    wr(2'd0, 8'hFF);
    cyc(3);
    chk("R7 pd latch1", pd_en_o, 8'h00);
    chk("R7 spu latch1", spu_en_o, 8'h10);
    chk("R7 wpu latch1", wpu_en_o, 8'hC0);

    // R9 kick: all quasi-bidirectional, latch 0 -> 1
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    cyc(3);
    wr(2'd0, 8'hFF);
    chk("R9 kick clk1", spu_en_o, 8'hDF);
    chk("R9 weak clk1", wpu_en_o, 8'hDF);
    cyc(1);
    chk("R9 kick clk2", spu_en_o, 8'hDF);
    cyc(1);
    chk("R9 kick end", spu_en_o, 8'h00);
    chk("R3 weak only", wpu_en_o, 8'hDF);

    // random modes and latch
    for (int it = 0; it < 40; it++) begin
      ra = W'($urandom); rb = W'($urandom); rl = W'($urandom);
      wr(2'd1, ra); wr(2'd2, rb); wr(2'd0, rl);
      cyc(3);
      for (int p = 0; p < W; p++) begin
        chk($sformatf("%s pin%0d", mode_tag(ra[p], rb[p], p), p),
            {29'd0, pd_en_o[p], spu_en_o[p], wpu_en_o[p]},
            {29'd0, exp_drv(ra[p], rb[p], rl[p], p)});
      end
    end

    // R11 latency
    @(negedge clk); pad_in_i = 8'h01;
    cyc(4); rd(2'd0, d); chk("R11 edge4", d, 8'h00);
    cyc(1); rd(2'd0, d); chk("R11 edge5", d, 8'h01);

    // R12 glitch reject / pass
    @(negedge clk); pad_in_i = 8'h03;
    cyc(2); pad_in_i = 8'h01;
    cyc(8); rd(2'd0, d); chk("R12 2clk reject", d, 8'h01);
    pad_in_i = 8'h05;
    cyc(3); pad_in_i = 8'h01;
    cyc(2); rd(2'd0, d); chk("R12 3clk pass", d, 8'h05);
    cyc(8);

    // R10 analog gate and hold
    wr(2'd3, 8'h01);
    chk("R10 din", din_en_o, 8'hFE);
    rd(2'd0, d); chk("R10 read0", d, 8'h00);
    pad_in_i = 8'h00;
    cyc(8);
    wr(2'd3, 8'h00);
    rd(2'd0, d); chk("R10 held", d, 8'h01);
    cyc(6);
    rd(2'd0, d); chk("R10 resume", d, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule